// File: doc/BRIEF.md
# Scalar AES Byte-Round Execution Unit

This unit sits beside the integer pipeline of a 32-bit RISC-V core and executes the four scalar AES instructions. Two of them encrypt and two decrypt. In each pair, one form ends with a MixColumns contribution (the "middle" round) and the other does not (the "final" round). Every instruction handles one byte. The unit picks a byte of the second operand using a 2-bit immediate and passes it through the forward or inverse S-box. It then expands the result into a one-column MixColumns word, or leaves it unexpanded for the final round. That word is rotated into the selected byte lane and XORed into the first operand. Software builds a full AES round by chaining sixteen of these operations through an accumulator register.

Decoding and the extension enables are handled inside the unit. A word that does not encode one of the four operations, or whose extension is switched off, raises a combinational reject flag in the same cycle. Accepted work lands in a result register one clock later, together with a valid pulse. Rejected or idle cycles leave the result register unchanged.

Top module: `aesb_round_unit`

## Requirements
- R1: An instruction is recognised only when all three of these hold: bits 14:12 equal 000, bits 6:0 equal 0110011, and bits 29:25 equal one of 10001 (encrypt final), 10011 (encrypt middle), 10101 (decrypt final) or 10111 (decrypt middle). Any other word presented with `in_valid` high drives `reject` high in the same cycle.
- R2: Encrypt encodings are accepted only while `enc_en` is high, and decrypt encodings only while `dec_en` is high. A disabled encoding drives `reject` high. `reject` is low whenever `in_valid` is low.
- R3: Bits 31:30 form a lane index k. The processed byte is bits [8k+7:8k] of `op_b`.
- R4: Encrypt operations use the standard AES forward S-box (for example 0x00→0x63 and 0x53→0xED). Decrypt operations use its inverse (for example 0x63→0x00 and 0x00→0x52).
- R5: Encrypt middle builds the word {3·s, s, s, 2·s}, most significant byte first, with products taken in GF(2^8) modulo 0x11B.
- R6: Decrypt middle builds the word {0x0B·s, 0x0D·s, 0x09·s, 0x0E·s}, most significant byte first.
- R7: The two final operations build the word as the S-box output zero-extended to 32 bits.
- R8: The word is rotated left by 8k bits and XORed with `op_a` to form the result.
- R9: After a cycle in which `in_valid` is high and the instruction is accepted, `out_valid` is high for one cycle and `result` carries the new value.
- R10: After any cycle that is idle or rejected, `out_valid` is low and `result` keeps its previous value.
- R11: A synchronous active-low reset clears `out_valid` and `result` to zero. Reset takes priority over an input presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Instruction word |
| op_a | input | 32 | Accumulator operand |
| op_b | input | 32 | Operand that supplies the state byte |
| enc_en | input | 1 | Enables the encrypt operations |
| dec_en | input | 1 | Enables the decrypt operations |
| reject | output | 1 | Combinational: the instruction is not accepted |
| out_valid | output | 1 | Result is new this cycle |
| result | output | 32 | Registered result |

## Verification
The hardest behaviour to reach from the ports is full coverage of both S-box directions across all four byte lanes. Each instruction exposes only one byte, after it has been rotated and XORed with an arbitrary accumulator. The bench builds its own forward table from a brute-force field inverse and an affine map, and it derives the inverse table by searching that forward table. It then drives long back-to-back runs with random lanes, operands and enable combinations. These runs are mixed with reject cases and a reset asserted together with a live input. Every cycle is compared against this model.

// File: rtl/aesb_pkg.sv
// Shared types and GF(2^8) helpers for the scalar AES byte-round unit.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1.
package aesb_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_ENC_FIN = 3'd1,
        OP_ENC_MID = 3'd2,
        OP_DEC_FIN = 3'd3,
        OP_DEC_MID = 3'd4
    } aesb_op_e;

    // Multiply by x in the AES field.
    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General field product by shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] cur;
        acc = 8'h00;
        cur = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ cur;
            cur = xtime(cur);
        end
        return acc;
    endfunction

    // Rotate a byte left by n.
    function automatic logic [7:0] rol8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

endpackage

// File: rtl/aesb_decode.sv
// Decoder: maps the opcode, funct3 and function bits to one of four
// operations and applies the per-direction enables. Purely combinational.
// Assumes the caller qualifies the result with its own valid strobe.
module aesb_decode
    import aesb_pkg::*;
(
    input  logic [6:0] funct_hi,   // instruction bits 31:25
    input  logic [2:0] funct3,     // instruction bits 14:12
    input  logic [6:0] opcode,     // instruction bits 6:0
    input  logic       enc_en,
    input  logic       dec_en,
    output aesb_op_e   op,
    output logic       accept,
    output logic [1:0] lane
);

    logic       base_ok;
    logic [4:0] fsel;

    assign base_ok = (funct3 == 3'b000) && (opcode == 7'b0110011);
    assign fsel    = funct_hi[4:0];
    assign lane    = funct_hi[6:5];

    // Select the operation when the encoding matches and its direction is enabled.
    always_comb begin
        op = OP_NONE;
        if (base_ok) begin
            unique case (fsel)
                5'b10001: if (enc_en) op = OP_ENC_FIN;
                5'b10011: if (enc_en) op = OP_ENC_MID;
                5'b10101: if (dec_en) op = OP_DEC_FIN;
                5'b10111: if (dec_en) op = OP_DEC_MID;
                default:  op = OP_NONE;
            endcase
        end
    end

    assign accept = (op != OP_NONE);

endmodule

// File: rtl/aesb_sbox.sv
// Bidirectional AES S-box computed from a shared field inverter.
// Forward path: inverse then affine map. Inverse path: inverse affine map
// then inverse. Assumes a single-cycle combinational budget.
module aesb_sbox
    import aesb_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    input  logic              inv_dir,
    output logic [BYTE_W-1:0] dout
);

    logic [7:0] pre;
    logic [7:0] recip;

    // Field inverse as a^254 through a fixed square-and-multiply chain.
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] p2, p3, p6, p12, p15, p30, p60, p120, p240, p252;
        p2   = gf_mul(a, a);
        p3   = gf_mul(p2, a);
        p6   = gf_mul(p3, p3);
        p12  = gf_mul(p6, p6);
        p15  = gf_mul(p12, p3);
        p30  = gf_mul(p15, p15);
        p60  = gf_mul(p30, p30);
        p120 = gf_mul(p60, p60);
        p240 = gf_mul(p120, p120);
        p252 = gf_mul(p240, p12);
        return gf_mul(p252, p2);
    endfunction

    function automatic logic [7:0] affine_fwd(input logic [7:0] b);
        return b ^ rol8(b, 1) ^ rol8(b, 2) ^ rol8(b, 3) ^ rol8(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] affine_inv(input logic [7:0] s);
        return rol8(s, 1) ^ rol8(s, 3) ^ rol8(s, 6) ^ 8'h05;
    endfunction

    // Undo the affine map before the inverter when running backwards.
    always_comb pre = inv_dir ? affine_inv(din) : din;

    // One inverter serves both directions.
    always_comb recip = gf_inv(pre);

    // Apply the affine map after the inverter when running forwards.
    always_comb dout = inv_dir ? recip : affine_fwd(recip);

endmodule

// File: rtl/aesb_mix.sv
// One-column MixColumns contribution of a single substituted byte.
// Builds the 32-bit word for the middle forms, or zero-extends the byte for
// the final forms. Assumes exactly one of the operation flags is active.
module aesb_mix
    import aesb_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic [BYTE_W-1:0] s,
    input  logic              enc,
    input  logic              mix_en,
    output logic [WORD_W-1:0] word
);

    localparam int unsigned LANES = WORD_W / BYTE_W;

    logic [BYTE_W-1:0] coef_e [LANES];
    logic [BYTE_W-1:0] coef_d [LANES];
    logic [BYTE_W-1:0] x2, x4, x8;

    assign x2 = xtime(s);
    assign x4 = xtime(x2);
    assign x8 = xtime(x4);

    // Byte products, listed from lane 0 (least significant) upward.
    always_comb begin
        coef_e[0] = x2;
        coef_e[1] = s;
        coef_e[2] = s;
        coef_e[3] = x2 ^ s;
        coef_d[0] = x8 ^ x4 ^ x2;
        coef_d[1] = x8 ^ s;
        coef_d[2] = x8 ^ x4 ^ s;
        coef_d[3] = x8 ^ x2 ^ s;
    end

    // Assemble each lane from the product the operation calls for.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (mix_en)
                word[g*BYTE_W +: BYTE_W] = enc ? coef_e[g] : coef_d[g];
            else if (g == 0)
                word[g*BYTE_W +: BYTE_W] = s;
            else
                word[g*BYTE_W +: BYTE_W] = '0;
        end
    end

endmodule

// File: rtl/aesb_round_unit.sv
// Scalar AES byte-round execution unit (top). Decodes one of four
// instructions, substitutes a selected byte of op_b, optionally expands it
// to a MixColumns column, rotates it into its lane and XORs it into op_a.
// The result is registered; reject is combinational. Assumes WORD_W = 32.
module aesb_round_unit
    import aesb_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              enc_en,
    input  logic              dec_en,
    output logic              reject,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);

    localparam int unsigned LANES = WORD_W / BYTE_W;
    localparam int unsigned SEL_W = $clog2(LANES);

    aesb_op_e           op;
    logic               accept;
    logic [SEL_W-1:0]   lane;
    logic [BYTE_W-1:0]  picked;
    logic [BYTE_W-1:0]  subst;
    logic [WORD_W-1:0]  col_word;
    logic [WORD_W-1:0]  rotated;
    logic [WORD_W-1:0]  next_result;
    logic               is_enc;
    logic               is_mid;
    logic               fire;
    logic               unused_fields;

    assign unused_fields = ^{instr[24:15], instr[11:7]};

    aesb_decode u_dec (
        .funct_hi (instr[31:25]),
        .funct3   (instr[14:12]),
        .opcode   (instr[6:0]),
        .enc_en   (enc_en),
        .dec_en   (dec_en),
        .op       (op),
        .accept   (accept),
        .lane     (lane)
    );

    assign is_enc = (op == OP_ENC_FIN) || (op == OP_ENC_MID);
    assign is_mid = (op == OP_ENC_MID) || (op == OP_DEC_MID);
    assign fire   = in_valid && accept;
    assign reject = in_valid && !accept;

    // Pick the lane-selected byte of op_b.
    always_comb picked = op_b[lane*BYTE_W +: BYTE_W];

    aesb_sbox u_sbox (
        .din     (picked),
        .inv_dir (!is_enc),
        .dout    (subst)
    );

    aesb_mix #(.WORD_W(WORD_W)) u_mix (
        .s      (subst),
        .enc    (is_enc),
        .mix_en (is_mid),
        .word   (col_word)
    );

    // Rotate the column word left into the chosen lane.
    for (genvar g = 0; g < LANES; g++) begin : g_rot
        always_comb rotated[((g + lane) % LANES)*BYTE_W +: BYTE_W] = col_word[g*BYTE_W +: BYTE_W];
    end

    // Accumulate into the first operand.
    always_comb next_result = op_a ^ rotated;

    // Result register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= fire;
            if (fire) result <= next_result;
        end
    end

    // R9
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (out_valid && result == $past(next_result)));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (!out_valid && $stable(result)));

    // R2
    enc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && accept && is_enc) |-> enc_en);

    // R2
    dec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && accept && !is_enc) |-> dec_en);

    // R7
    final_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !is_mid) |-> (col_word[WORD_W-1:BYTE_W] == '0));

endmodule

// File: tb/sim_aesb_round_unit.sv
module sim_aesb_round_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        enc_en = 1'b0;
    logic        dec_en = 1'b0;
    logic        reject;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;

    logic [7:0] fwd_t [256];
    logic [7:0] inv_t [256];

    logic        exp_valid = 1'b0;
    logic [31:0] exp_result = '0;

    always #5 clk = ~clk;

    aesb_round_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .op_a(op_a), .op_b(op_b), .enc_en(enc_en), .dec_en(dec_en),
        .reject(reject), .out_valid(out_valid), .result(result)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        int r = 0;
        int x = a;
        for (int i = 0; i < 8; i++) begin
            if ((b >> i) & 1) r = r ^ x;
            x = x << 1;
            if (x >= 256) x = x ^ 'h11b;
        end
        return r[7:0];
    endfunction

    function automatic logic [7:0] brot(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [31:0] mk(input int k, input logic [4:0] f, input logic [2:0] f3, input logic [6:0] opc);
        return {k[1:0], f, 5'd7, 5'd11, f3, 5'd3, opc};
    endfunction

    function automatic logic model_accept(input logic [31:0] ins, input logic ee, input logic de);
        logic [4:0] f = ins[29:25];
        if (ins[14:12] != 3'b000 || ins[6:0] != 7'h33) return 1'b0;
        if ((f == 5'b10001 || f == 5'b10011) && ee) return 1'b1;
        if ((f == 5'b10101 || f == 5'b10111) && de) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] model_result(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        int k = ins[31:30];
        logic [4:0] f = ins[29:25];
        logic enc = (f == 5'b10001 || f == 5'b10011);
        logic [7:0] x = 8'(b >> (8 * k));
        logic [7:0] s = enc ? fwd_t[x] : inv_t[x];
        logic [31:0] w;
        if (!f[1]) w = {24'h0, s};
        else if (enc) w = {bmul(s, 3), s, s, bmul(s, 2)};
        else w = {bmul(s, 8'h0b), bmul(s, 8'h0d), bmul(s, 8'h09), bmul(s, 8'h0e)};
        if (k != 0) w = (w << (8 * k)) | (w >> (32 - 8 * k));
        return a ^ w;
    endfunction

    // One cycle of stimulus, model update and comparison (R1, R2, R9, R10).
    task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input logic ee, input logic de, input string tag);
        logic acc;
        in_valid = v; instr = ins; op_a = a; op_b = b; enc_en = ee; dec_en = de;
        acc = model_accept(ins, ee, de);
        #1;
        check({tag, " reject"}, {31'h0, reject}, {31'h0, v && !acc});
        @(posedge clk);
        exp_valid = v && acc;
        if (v && acc) exp_result = model_result(ins, a, b);
        @(negedge clk);
        check({tag, " out_valid"}, {31'h0, out_valid}, {31'h0, exp_valid});
        check({tag, " result"}, result, exp_result);
    endtask

    localparam logic [4:0] F_EF = 5'b10001, F_EM = 5'b10011, F_DF = 5'b10101, F_DM = 5'b10111;
    localparam logic [6:0] OPC = 7'b0110011;

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Bench-side tables: inverse by search, then affine map.
        for (int x = 0; x < 256; x++) begin
            logic [7:0] iv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (bmul(x[7:0], y[7:0]) == 8'h01) iv = y[7:0];
            fwd_t[x] = iv ^ brot(iv, 1) ^ brot(iv, 2) ^ brot(iv, 3) ^ brot(iv, 4) ^ 8'h63;
        end
        for (int x = 0; x < 256; x++) inv_t[fwd_t[x]] = x[7:0];

        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset out_valid", {31'h0, out_valid}, 32'h0);
        check("R11 reset result", result, 32'h0);
        rst_n = 1'b1;

        // R4, R7: known S-box values through final forms
        step(1, mk(0, F_EF, 0, OPC), 0, 32'h00, 1, 1, "R4 fwd 00");
        check("R4 sbox(00)", result, 32'h0000_0063);
        step(1, mk(0, F_EF, 0, OPC), 0, 32'h53, 1, 1, "R4 fwd 53");
        check("R4 sbox(53)", result, 32'h0000_00ed);
        step(1, mk(0, F_DF, 0, OPC), 0, 32'h63, 1, 1, "R4 inv 63");
        check("R4 isbox(63)", result, 32'h0);
        step(1, mk(0, F_DF, 0, OPC), 0, 32'h00, 1, 1, "R7 inv 00");
        check("R7 isbox(00) zero-extended", result, 32'h0000_0052);
        // R5, R6: column words
        step(1, mk(0, F_EM, 0, OPC), 0, 32'h00, 1, 1, "R5 enc mid");
        check("R5 column 63", result, 32'ha563_63c6);
        step(1, mk(0, F_DM, 0, OPC), 0, 32'h00, 1, 1, "R6 dec mid");
        check("R6 column 52", result, 32'h50a7_f451);
        // R3, R8: lane select, rotation and accumulation
        step(1, mk(3, F_EF, 0, OPC), 32'hffff_ffff, 32'h5300_0000, 1, 1, "R3 lane3");
        check("R8 rotate xor", result, 32'h12ff_ffff);
        step(1, mk(1, F_EM, 0, OPC), 32'h0, 32'h0000_0000, 1, 1, "R8 lane1 mid");
        check("R8 rotate 8", result, 32'h6363_c6a5);
        // R2, R10: disabled direction rejected, result held
        step(1, mk(0, F_EF, 0, OPC), 0, 32'h01, 0, 1, "R2 enc off");
        check("R10 hold after reject", result, 32'h6363_c6a5);
        step(1, mk(0, F_DM, 0, OPC), 0, 32'h01, 1, 0, "R2 dec off");
        // R1: bad encodings
        step(1, mk(0, 5'b10011, 3'b001, OPC), 0, 0, 1, 1, "R1 funct3");
        step(1, mk(0, F_EF, 0, 7'h13), 0, 0, 1, 1, "R1 opcode");
        step(1, mk(0, 5'b11001, 0, OPC), 0, 0, 1, 1, "R1 funct");
        // R10: idle cycle holds
        step(0, mk(0, F_EF, 0, OPC), 32'h1234, 0, 1, 1, "R10 idle");
        check("R10 idle hold", result, 32'h6363_c6a5);

        // Random sweep (R1..R10)
        for (int n = 0; n < 600; n++) begin
            logic [31:0] rb = $urandom;
            logic [4:0]  f;
            int pick = $urandom_range(0, 9);
            case (pick)
                0, 1: f = F_EF;
                2, 3: f = F_EM;
                4, 5: f = F_DF;
                6, 7: f = F_DM;
                default: f = 5'($urandom);
            endcase
            step(($urandom_range(0, 7) != 0), mk($urandom_range(0, 3), f,
                 ($urandom_range(0, 15) == 0) ? 3'b010 : 3'b000, OPC),
                 $urandom, rb, ($urandom_range(0, 5) != 0), ($urandom_range(0, 5) != 0), "R3 R8 sweep");
        end

        // R11: reset wins over a live instruction
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; instr = mk(0, F_EF, 0, OPC); enc_en = 1'b1;
        @(posedge clk);
        exp_valid = 1'b0; exp_result = '0;
        @(negedge clk);
        check("R11 mid reset out_valid", {31'h0, out_valid}, 32'h0);
        check("R11 mid reset result", result, 32'h0);
        rst_n = 1'b1;
        step(1, mk(2, F_DF, 0, OPC), 32'h0, 32'h0063_0000, 1, 1, "R9 after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule